// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-programmed master for the two-wire station management bus used between Ethernet MACs and PHYs. Software loads a 16-bit address word and a 16-bit write word into their registers. It then writes a command word that selects the frame flavour (the short-address style with a 5-bit register number, or the extended style that first sends a 16-bit register address and then moves data). The same command word carries the opcode, the 5-bit port address and the 5-bit device or register number, plus a start bit.

Once started, the block takes a snapshot of everything the frame needs. It generates the management clock from the system clock and shifts the frame out MSB first. On read frames it releases the data line at the turnaround and captures the sixteen data bits returned by the PHY. The start bit reads back as 1 until the frame is over, and software polls it. After a read, software checks a status flag that tells whether the PHY answered before it uses the read data.

Top module: `mdio_master`

## Requirements
- R1: Register byte offsets are 0x00 command, 0x04 address word, 0x08 write word, 0x0C read word and 0x10 status. The address, write and read words occupy bits 15:0. The command register reads back bits 13:0 as last accepted and bit 14 as the busy flag. All other bits read as 0.
- R2: The command layout is bits 4:0 device/register number, bits 9:5 port address, bits 11:10 opcode, bits 13:12 start selector and bit 14 start. A command write with bit 14 set launches one frame. Bit 14 then reads 1 from the next cycle until the frame ends and reads 0 afterwards. A command write with bit 14 clear only stores the fields and produces no frame.
- R3: A frame is 64 bit times sent MSB first: 32 ones, then the 2-bit start code, the 2-bit opcode, the 5-bit port address, the 5-bit device/register number, a 2-bit turnaround and 16 data bits. The start code equals the selector, so selector 1 sends 01 (short style) and selector 0 sends 00 (extended style).
- R4: On frames that are not reads, the master drives the turnaround as 10. The data field is the address word when the selector is 0 with opcode 0, and the write word otherwise.
- R5: Reads are selector 1 with opcode 2, and selector 0 with opcode 2 or 3. On a read the master stops driving the line from the first turnaround bit to the end of the frame. The 16 bits sampled in the data field appear in the read word after the frame.
- R6: Status bit 0 is updated only when a read frame ends. It is 1 when the second turnaround bit sampled high (no PHY answer) and 0 when that bit sampled low.
- R7: The management clock has a period of 2*DIV_HALF system clocks and idles low after reset. The data line and its output enable change only together with a falling management clock edge, and the line is sampled on the rising edge.
- R8: A command write that arrives while the busy flag is set is ignored: no field changes and no extra frame.
- R9: Writes to the address or write word during a frame do not alter the frame in progress.
- R10: After reset, all registers read 0, the management clock is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data for the offset presented in the previous cycle |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The assertions check several properties on every cycle. The management clock half period must be exact. The data line and its enable may change only at a falling clock edge. The enable may be on only while busy. A command written while busy must leave the stored fields alone. The status flag may move only when a frame finishes. Frame content cannot be seen by a cycle-local property, so the bench supplies it. A PHY stub collects each 64-bit frame as it appears on the line, and a scoreboard compares it with the frame predicted from the register contents. The bench scenarios also cover read data capture, the no-answer status flag, and the snapshot taken under mid-frame register writes.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_FIRST   = 46;  // first turnaround bit time
  localparam int TA_SECOND  = 47;  // bit the PHY must pull low
  localparam int DATA_FIRST = 48;

  localparam logic [4:0] OFS_CMD   = 5'h00;
  localparam logic [4:0] OFS_ADDR  = 5'h04;
  localparam logic [4:0] OFS_WDAT  = 5'h08;
  localparam logic [4:0] OFS_RDAT  = 5'h0C;
  localparam logic [4:0] OFS_STAT  = 5'h10;

  localparam int START_BIT = 14;

  // field order matches command bits 13:0
  typedef struct packed {
    logic [1:0] st;
    logic [1:0] op;
    logic [4:0] prt;
    logic [4:0] dev;
  } cmd_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ARM   = 2'd1,
    SQ_SHIFT = 2'd2
  } seq_state_t;

  function automatic logic is_read_op(cmd_t c);
    logic r;
    if (c.st == 2'b01)      r = (c.op == 2'b10);
    else if (c.st == 2'b00) r = c.op[1];
    else                    r = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_HALF = 20
) (
  input  logic clk,
  input  logic rst,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap     = (cnt_q == LAST);
  assign rise_stb = wrap && !mdc;
  assign fall_stb = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              seq_done,
  input  logic              seq_rd_done,
  input  logic [15:0]       seq_rd_val,
  input  logic              seq_rd_fail,
  output logic              launch,
  output logic              busy,
  output logic              cmd_wr,
  output cmd_t              cmd_fields,
  output logic [15:0]       addr_word,
  output logic [15:0]       wr_word,
  output logic              status_bit
);
  logic [15:0] rd_word;
  logic        unused_hi;

  assign unused_hi = ^bus_wdata[31:15];
  assign cmd_wr    = bus_we && (bus_addr == ADDR_W'(OFS_CMD));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_fields <= '0;
      busy       <= 1'b0;
      launch     <= 1'b0;
      addr_word  <= '0;
      wr_word    <= '0;
      rd_word    <= '0;
      status_bit <= 1'b0;
    end else begin
      launch <= 1'b0;
      if (cmd_wr && !busy) begin
        cmd_fields <= cmd_t'(bus_wdata[13:0]);
        if (bus_wdata[START_BIT]) begin
          busy   <= 1'b1;
          launch <= 1'b1;
        end
      end else if (seq_done) begin
        busy <= 1'b0;
      end
      if (bus_we && bus_addr == ADDR_W'(OFS_ADDR)) addr_word <= bus_wdata[15:0];
      if (bus_we && bus_addr == ADDR_W'(OFS_WDAT)) wr_word   <= bus_wdata[15:0];
      if (seq_rd_done) begin
        rd_word    <= seq_rd_val;
        status_bit <= seq_rd_fail;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (bus_addr)
        ADDR_W'(OFS_CMD):  bus_rdata <= {17'd0, busy, cmd_fields};
        ADDR_W'(OFS_ADDR): bus_rdata <= {16'd0, addr_word};
        ADDR_W'(OFS_WDAT): bus_rdata <= {16'd0, wr_word};
        ADDR_W'(OFS_RDAT): bus_rdata <= {16'd0, rd_word};
        ADDR_W'(OFS_STAT): bus_rdata <= {31'd0, status_bit};
        default:           bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rise_stb,
  input  logic        fall_stb,
  input  logic        launch,
  input  cmd_t        cmd_fields,
  input  logic [15:0] addr_word,
  input  logic [15:0] wr_word,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic        rd_done,
  output logic [15:0] rd_val,
  output logic        rd_fail
);
  localparam int IW = $clog2(FRAME_BITS + 1);

  seq_state_t            state_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [IW-1:0]         idx_q;
  logic [IW-1:0]         idx_nx;
  logic                  rd_q;
  logic                  fail_q;
  logic [15:0]           cap_q;
  logic                  rd_new;
  logic [15:0]           payload;
  logic [FRAME_BITS-1:0] frame;

  assign rd_new  = is_read_op(cmd_fields);
  assign payload = (cmd_fields.st == 2'b00 && cmd_fields.op == 2'b00) ? addr_word : wr_word;
  assign frame   = {{PRE_BITS{1'b1}}, cmd_fields.st, cmd_fields.op, cmd_fields.prt,
                    cmd_fields.dev, (rd_new ? 2'b11 : 2'b10), payload};
  assign idx_nx  = idx_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      sh_q    <= '0;
      idx_q   <= '0;
      rd_q    <= 1'b0;
      fail_q  <= 1'b0;
      cap_q   <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
      rd_done <= 1'b0;
      rd_val  <= '0;
      rd_fail <= 1'b0;
    end else begin
      done    <= 1'b0;
      rd_done <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (launch) begin
            sh_q    <= frame;
            rd_q    <= rd_new;
            fail_q  <= 1'b0;
            cap_q   <= '0;
            state_q <= SQ_ARM;
          end
        end
        SQ_ARM: begin
          if (fall_stb) begin
            mdio_o  <= sh_q[FRAME_BITS-1];
            mdio_oe <= 1'b1;
            sh_q    <= {sh_q[FRAME_BITS-2:0], 1'b1};
            idx_q   <= '0;
            state_q <= SQ_SHIFT;
          end
        end
        SQ_SHIFT: begin
          if (fall_stb) begin
            if (idx_q == IW'(FRAME_BITS - 1)) begin
              mdio_o  <= 1'b1;
              mdio_oe <= 1'b0;
              done    <= 1'b1;
              rd_done <= rd_q;
              rd_val  <= cap_q;
              rd_fail <= fail_q;
              state_q <= SQ_IDLE;
            end else begin
              mdio_o  <= sh_q[FRAME_BITS-1];
              mdio_oe <= !(rd_q && idx_nx >= IW'(TA_FIRST));
              sh_q    <= {sh_q[FRAME_BITS-2:0], 1'b1};
              idx_q   <= idx_nx;
            end
          end else if (rise_stb && rd_q) begin
            if (idx_q == IW'(TA_SECOND)) fail_q <= mdio_i;
            if (idx_q >= IW'(DATA_FIRST)) cap_q <= {cap_q[14:0], mdio_i};
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 20,
  parameter int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic        rise_stb, fall_stb;
  logic        launch, busy, cmd_wr, status_bit;
  cmd_t        cmd_fields;
  logic [15:0] addr_word, wr_word, rd_val;
  logic        done, rd_done, rd_fail;

  mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
    .clk(clk), .rst(rst), .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .seq_done(done), .seq_rd_done(rd_done), .seq_rd_val(rd_val),
    .seq_rd_fail(rd_fail), .launch(launch), .busy(busy), .cmd_wr(cmd_wr),
    .cmd_fields(cmd_fields), .addr_word(addr_word), .wr_word(wr_word),
    .status_bit(status_bit)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst(rst), .rise_stb(rise_stb), .fall_stb(fall_stb),
    .launch(launch), .cmd_fields(cmd_fields), .addr_word(addr_word),
    .wr_word(wr_word), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done), .rd_done(rd_done), .rd_val(rd_val), .rd_fail(rd_fail)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int DIV_HALF = 20
) (
  input logic        clk,
  input logic        rst,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic        cmd_wr,
  input logic [13:0] cmd_fields,
  input logic        status_bit
);
  logic mdc_prev;
  int   half_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_prev <= 1'b0;
      half_cnt <= 0;
    end else begin
      mdc_prev <= mdc;
      half_cnt <= (mdc != mdc_prev) ? 1 : half_cnt + 1;
    end
  end

  AST_MDC_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (mdc != mdc_prev) |-> (half_cnt == DIV_HALF)); // R7

  AST_LINE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable({mdio_o, mdio_oe}) |-> $fell(mdc)); // R7

  AST_DRIVE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> busy); // R2

  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_wr) |=> $stable(cmd_fields)); // R8

  AST_STATUS_AT_END: assert property (@(posedge clk) disable iff (rst)
    !$stable(status_bit) |-> $fell(busy)); // R6
endmodule

bind mdio_master mdio_master_chk #(.DIV_HALF(DIV_HALF)) u_chk (
  .clk(clk), .rst(rst), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .cmd_wr(cmd_wr), .cmd_fields(cmd_fields), .status_bit(status_bit)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int DH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  logic        phy_oe = 1'b0, phy_o = 1'b1;
  logic        resp_en = 1'b0;
  logic [15:0] resp = '0;
  int          pcnt = 0;
  logic [63:0] pcap = '0;
  logic        prd = 1'b0;
  int          frames_seen = 0;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

  mdio_master #(.DIV_HALF(DH), .ADDR_W(5)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // PHY stub and scoreboard monitor
  always @(posedge mdc) begin
    if (pcnt > 0 || mdio_oe) begin
      pcap = {pcap[62:0], mdio_i};
      pcnt++;
      if (pcnt == 36)
        prd = (pcap[3:2] == 2'b01 && pcap[1:0] == 2'b10) || (pcap[3:2] == 2'b00 && pcap[1]);
      if (pcnt == 64) begin
        frames_seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected frame", pcap, 64'h0);
        end else begin
          logic [63:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(pcap == e, t, pcap, e);
        end
        pcnt = 0;
        prd = 1'b0;
      end
    end
  end

  always @(negedge mdc) begin
    if (prd && resp_en && pcnt >= 47 && pcnt <= 63) begin
      phy_oe = 1'b1;
      phy_o  = (pcnt == 47) ? 1'b0 : resp[63 - pcnt];
    end else begin
      phy_oe = 1'b0;
    end
  end

  function automatic logic [63:0] mkframe(input logic [1:0] st, input logic [1:0] op,
      input logic [4:0] prt, input logic [4:0] dev, input logic [1:0] ta, input logic [15:0] d);
    return {32'hFFFF_FFFF, st, op, prt, dev, ta, d};
  endfunction

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    int n = 0;
    do begin
      bus_read(5'h00, d);
      n++;
    end while (d[14] && n < 5000);
  endtask

  // driver: predicts the frame, pushes it, then starts it
  task automatic issue(input logic [1:0] st, input logic [1:0] op, input logic [4:0] prt,
      input logic [4:0] dev, input logic [1:0] ta, input logic [15:0] d, input string tag);
    exp_q.push_back(mkframe(st, op, prt, dev, ta, d));
    tag_q.push_back(tag);
    bus_write(5'h00, {17'd0, 1'b1, st, op, prt, dev});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int t0, t1, fs;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R10 reset state
    check(mdc == 1'b0, "R10 mdc low", {63'd0, mdc}, 64'd0);
    check(mdio_oe == 1'b0, "R10 oe low", {63'd0, mdio_oe}, 64'd0);
    bus_read(5'h00, d); check(d == 0, "R10 cmd reg", {32'd0, d}, 64'd0);
    bus_read(5'h10, d); check(d == 0, "R10 status reg", {32'd0, d}, 64'd0);

    // R1 register readback, upper bits dropped
    bus_write(5'h04, 32'h1234_ABCD);
    bus_read(5'h04, d); check(d == 32'h0000_ABCD, "R1 address word", {32'd0, d}, 64'h0000_ABCD);
    bus_write(5'h08, 32'hFFFF_5A5A);
    bus_read(5'h08, d); check(d == 32'h0000_5A5A, "R1 write word", {32'd0, d}, 64'h5A5A);

    // R2 command without start: stored, no frame
    bus_write(5'h00, 32'h0000_3FFF);
    bus_read(5'h00, d); check(d == 32'h3FFF, "R2 fields no start", {32'd0, d}, 64'h3FFF);
    repeat (600) @(posedge clk);
    check(frames_seen == 0, "R2 no frame without start", frames_seen, 0);

    // R7 management clock period
    @(posedge mdc); t0 = $time;
    @(posedge mdc); t1 = $time;
    check((t1 - t0) == 2 * DH * 10, "R7 mdc period", t1 - t0, 2 * DH * 10);

    // R3 R4 short write; R8 R9 mid-frame writes
    bus_write(5'h08, 32'h0000_BEEF);
    issue(2'b01, 2'b01, 5'd5, 5'd3, 2'b10, 16'hBEEF, "R3 R4 short write frame");
    bus_read(5'h00, d);
    check(d == {17'd0, 1'b1, 14'h0 | {2'b01, 2'b01, 5'd5, 5'd3}}, "R2 busy while running",
          {32'd0, d}, {46'd0, 1'b1, 2'b01, 2'b01, 5'd5, 5'd3});
    bus_write(5'h08, 32'h0000_1111);   // R9
    bus_write(5'h04, 32'h0000_7777);   // R9
    bus_write(5'h00, 32'h0000_7C21);   // R8 ignored
    wait_idle();
    bus_read(5'h00, d);
    check(d == {18'd0, 2'b01, 2'b01, 5'd5, 5'd3}, "R8 fields kept, R2 start cleared",
          {32'd0, d}, {50'd0, 2'b01, 2'b01, 5'd5, 5'd3});
    fs = frames_seen;
    repeat (700) @(posedge clk);
    check(frames_seen == 1 && fs == 1, "R8 no extra frame", frames_seen, 1);

    // R5 R6 short read with PHY answer
    resp_en = 1'b1; resp = 16'hC3A5;
    issue(2'b01, 2'b10, 5'h1F, 5'h1F, 2'b10, 16'hC3A5, "R5 short read frame");
    wait_idle();
    bus_read(5'h0C, d); check(d == 32'hC3A5, "R5 read word", {32'd0, d}, 64'hC3A5);
    bus_read(5'h10, d); check(d == 32'd0, "R6 status ok", {32'd0, d}, 64'd0);

    // R6 short read with no answer
    resp_en = 1'b0;
    issue(2'b01, 2'b10, 5'd1, 5'd2, 2'b11, 16'hFFFF, "R5 unanswered read frame");
    wait_idle();
    bus_read(5'h10, d); check(d == 32'd1, "R6 status failed", {32'd0, d}, 64'd1);
    bus_read(5'h0C, d); check(d == 32'hFFFF, "R5 floating data", {32'd0, d}, 64'hFFFF);

    // R4 extended address frame, status untouched by non-read
    bus_write(5'h04, 32'h0000_0102);
    issue(2'b00, 2'b00, 5'd2, 5'd7, 2'b10, 16'h0102, "R4 extended address frame");
    wait_idle();
    bus_read(5'h10, d); check(d == 32'd1, "R6 status held on write", {32'd0, d}, 64'd1);

    // R4 extended write
    bus_write(5'h08, 32'h0000_8001);
    issue(2'b00, 2'b01, 5'd2, 5'd7, 2'b10, 16'h8001, "R4 extended write frame");
    wait_idle();

    // R5 extended read (op 3), status clears
    resp_en = 1'b1; resp = 16'h00F0;
    issue(2'b00, 2'b11, 5'd9, 5'd30, 2'b10, 16'h00F0, "R5 extended read frame");
    wait_idle();
    bus_read(5'h0C, d); check(d == 32'h00F0, "R5 extended read word", {32'd0, d}, 64'h00F0);
    bus_read(5'h10, d); check(d == 32'd0, "R6 status cleared", {32'd0, d}, 64'd0);

    // R5 extended post-read-increment (op 2)
    resp = 16'h9999;
    issue(2'b00, 2'b10, 5'd9, 5'd30, 2'b10, 16'h9999, "R5 increment read frame");
    wait_idle();
    bus_read(5'h0C, d); check(d == 32'h9999, "R5 increment read word", {32'd0, d}, 64'h9999);

    repeat (50) @(posedge clk);
    check(exp_q.size() == 0, "R3 all frames seen", exp_q.size(), 0);
    check(mdio_oe == 1'b0, "R2 line released when idle", {63'd0, mdio_oe}, 64'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule